// File: doc/BRIEF.md
# Register Rename Status Table

This block keeps, for every architectural register, a record of whether a value for that register is still in flight and, if so, which reorder-buffer tag will produce it. When an issue group is accepted, each destination register is remapped to the tag that was allocated to its instruction. In the same cycle, every source register of the group is looked up. For each source the block reports where the operand comes from: the architectural register file, a reorder-buffer entry that has already written back, or a later broadcast of a pending tag on the result bus.

A writeback does not change the mapping. It only moves the reported source of a renamed register from the broadcast bus to the reorder buffer, and the block learns of it through a per-tag completion vector. An entry is released only by a commit whose tag still matches the stored mapping, or by a flush, which releases all entries at once. The register file, the reorder-buffer storage and the reservation stations are outside this block. Its outputs are source-select codes and tags only.

The issue group is a valid/ready stream. The group is taken on a clock edge where `iss_valid` and `iss_ready` are both high. `iss_ready` is low exactly while `flush` is high, so a group offered during a flush is not taken and leaves no mapping behind. The lookup outputs are combinational and describe the group currently presented.

Top module: `rename_status_table`

## Requirements
- R1: After reset every register reports source code 0 (register file) with tag 0.
- R2: An accepted issue slot with a write enable and a nonzero destination stores its tag for that register, and the next cycle's lookups of that register return that tag.
- R3: A lookup of a register with no mapping returns code 0 (register file) and tag 0.
- R4: A lookup of a mapped register whose tag has its bit set in `rob_done` returns code 1 (reorder buffer) with the stored tag.
- R5: A lookup of a mapped register whose tag has its `rob_done` bit clear returns code 2 (wait on result bus) with the stored tag. Code 3 never appears.
- R6: Writeback, seen as `rob_done` bits rising, leaves the mapping unchanged. The register keeps its tag and changes only from code 2 to code 1.
- R7: A commit whose register and tag match the stored mapping clears the entry, and the register then reports code 0.
- R8: A commit whose tag differs from the stored tag leaves the entry and its tag unchanged.
- R9: A flush clears every entry. `iss_ready` is low during the flush, and a group presented in that cycle stores nothing.
- R10: A source in slot s that names a register written by an older slot (index below s) of the same accepted group reports code 2 with the youngest such older slot's tag. A slot's own destination never affects its own sources.
- R11: When two slots of one accepted group write the same register, the higher-index (younger) slot's tag is stored.
- R12: Register 0 is never mapped. Every lookup of register 0 returns code 0, including within a group that names it as a destination.
- R13: When a rename and a matching commit hit the same register on the same edge, the new rename is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue group present |
| iss_ready | output | 1 | Group accepted this edge (low during flush) |
| iss_dst_we | input | ISSUE_W | Per-slot destination write enable |
| iss_dst | input | ISSUE_W*AREG_W | Per-slot destination register, slot 0 in the low bits |
| iss_tag | input | ISSUE_W*TAG_W | Per-slot allocated reorder-buffer tag |
| iss_src | input | ISSUE_W*2*AREG_W | Two source registers per slot, index slot*2+k |
| rob_done | input | ROB_DEPTH | Per-tag flag: entry has written back |
| cmt_valid | input | 1 | Commit of the oldest instruction |
| cmt_reg | input | AREG_W | Destination register of the committing instruction |
| cmt_tag | input | TAG_W | Tag of the committing instruction |
| flush | input | 1 | Misprediction or exception recovery |
| src_sel | output | ISSUE_W*2*2 | Per-source code: 0 register file, 1 reorder buffer, 2 result bus |
| src_tag | output | ISSUE_W*2*TAG_W | Per-source producer tag (0 when code is 0) |

## Verification
Two functions can act on one register on the same edge: a rename at issue and a commit carrying the old tag for that register. The bench causes this by committing a register's old tag while a new rename of that register is issued in the same cycle. A full-table sweep then checks that the new tag survived. Within one cycle, a younger slot's source lookup also coincides with an older slot's rename of the same register. The bench drives that group and compares the younger slot's code and tag with a bench-side model, and also confirms that the older slot still reads the previous mapping.

// File: rtl/rst_pkg.sv
package rst_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_ROB = 2'd1,
    SRC_BUS = 2'd2
  } src_sel_e;
endpackage

// File: rtl/rst_entry.sv
module rst_entry #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             ren_hit,
  input  logic [TAG_W-1:0] ren_tag,
  input  logic             cmt_hit,
  input  logic [TAG_W-1:0] cmt_tag,
  output logic             busy,
  output logic [TAG_W-1:0] tag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tag  <= '0;
    end else if (flush) begin
      busy <= 1'b0;
    end else if (ren_hit) begin
      busy <= 1'b1;
      tag  <= ren_tag;
    end else if (cmt_hit && busy && (tag == cmt_tag)) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/rst_src_lookup.sv
module rst_src_lookup #(
  parameter int NUM_ARCH  = 32,
  parameter int ROB_DEPTH = 16,
  parameter int ISSUE_W   = 2,
  parameter int SLOT      = 0,
  localparam int AREG_W   = $clog2(NUM_ARCH),
  localparam int TAG_W    = $clog2(ROB_DEPTH)
) (
  input  logic [AREG_W-1:0]         src_reg,
  input  logic                      fire,
  input  logic [NUM_ARCH-1:0]       busy_vec,
  input  logic [NUM_ARCH*TAG_W-1:0] tag_vec,
  input  logic [ISSUE_W-1:0]        dst_we,
  input  logic [ISSUE_W*AREG_W-1:0] dst,
  input  logic [ISSUE_W*TAG_W-1:0]  new_tag,
  input  logic [ROB_DEPTH-1:0]      rob_done,
  output rst_pkg::src_sel_e         sel,
  output logic [TAG_W-1:0]          tag
);
  logic             hit;
  logic             pend;
  logic [TAG_W-1:0] t;

  always_comb begin
    hit  = busy_vec[src_reg];
    t    = tag_vec[int'(src_reg)*TAG_W +: TAG_W];
    pend = 1'b0;
    for (int s = 0; s < ISSUE_W; s++) begin
      if ((s < SLOT) && fire && dst_we[s] &&
          (dst[s*AREG_W +: AREG_W] == src_reg)) begin
        hit  = 1'b1;
        t    = new_tag[s*TAG_W +: TAG_W];
        pend = 1'b1;
      end
    end
    if ((src_reg == '0) || !hit) begin
      sel = rst_pkg::SRC_RF;
      tag = '0;
    end else if (pend || !rob_done[t]) begin
      sel = rst_pkg::SRC_BUS;
      tag = t;
    end else begin
      sel = rst_pkg::SRC_ROB;
      tag = t;
    end
  end
endmodule

// File: rtl/rename_status_table.sv
module rename_status_table #(
  parameter int NUM_ARCH  = 32,
  parameter int ROB_DEPTH = 16,
  parameter int ISSUE_W   = 2,
  localparam int AREG_W   = $clog2(NUM_ARCH),
  localparam int TAG_W    = $clog2(ROB_DEPTH),
  localparam int NSRC     = ISSUE_W * 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      iss_valid,
  output logic                      iss_ready,
  input  logic [ISSUE_W-1:0]        iss_dst_we,
  input  logic [ISSUE_W*AREG_W-1:0] iss_dst,
  input  logic [ISSUE_W*TAG_W-1:0]  iss_tag,
  input  logic [NSRC*AREG_W-1:0]    iss_src,
  input  logic [ROB_DEPTH-1:0]      rob_done,
  input  logic                      cmt_valid,
  input  logic [AREG_W-1:0]         cmt_reg,
  input  logic [TAG_W-1:0]          cmt_tag,
  input  logic                      flush,
  output logic [NSRC*2-1:0]         src_sel,
  output logic [NSRC*TAG_W-1:0]     src_tag
);
  logic                      fire;
  logic [NUM_ARCH-1:0]       ren_hit;
  logic [TAG_W-1:0]          ren_tag [NUM_ARCH];
  logic [NUM_ARCH-1:0]       busy_vec;
  logic [NUM_ARCH*TAG_W-1:0] tag_vec;

  assign iss_ready = !flush;
  assign fire      = iss_valid && iss_ready;

  // Later slots overwrite earlier ones: the youngest writer wins.
  always_comb begin
    ren_hit = '0;
    for (int r = 0; r < NUM_ARCH; r++) ren_tag[r] = '0;
    for (int s = 0; s < ISSUE_W; s++) begin
      if (fire && iss_dst_we[s] && (iss_dst[s*AREG_W +: AREG_W] != '0)) begin
        ren_hit[iss_dst[s*AREG_W +: AREG_W]] = 1'b1;
        ren_tag[iss_dst[s*AREG_W +: AREG_W]] = iss_tag[s*TAG_W +: TAG_W];
      end
    end
  end

  for (genvar r = 0; r < NUM_ARCH; r++) begin : g_ent
    logic [TAG_W-1:0] e_tag;
    rst_entry #(.TAG_W(TAG_W)) u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .ren_hit (ren_hit[r]),
      .ren_tag (ren_tag[r]),
      .cmt_hit (cmt_valid && (cmt_reg == AREG_W'(r))),
      .cmt_tag (cmt_tag),
      .busy    (busy_vec[r]),
      .tag     (e_tag)
    );
    assign tag_vec[r*TAG_W +: TAG_W] = e_tag;
  end

  for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
    for (genvar k = 0; k < 2; k++) begin : g_src
      rst_pkg::src_sel_e sel_w;
      logic [TAG_W-1:0]  tag_w;
      rst_src_lookup #(
        .NUM_ARCH (NUM_ARCH),
        .ROB_DEPTH(ROB_DEPTH),
        .ISSUE_W  (ISSUE_W),
        .SLOT     (s)
      ) u_lk (
        .src_reg (iss_src[(s*2+k)*AREG_W +: AREG_W]),
        .fire    (fire),
        .busy_vec(busy_vec),
        .tag_vec (tag_vec),
        .dst_we  (iss_dst_we),
        .dst     (iss_dst),
        .new_tag (iss_tag),
        .rob_done(rob_done),
        .sel     (sel_w),
        .tag     (tag_w)
      );
      assign src_sel[(s*2+k)*2 +: 2]         = sel_w;
      assign src_tag[(s*2+k)*TAG_W +: TAG_W] = tag_w;
    end
  end
endmodule

// File: rtl/rst_checker.sv
module rst_checker #(
  parameter int NUM_ARCH  = 32,
  parameter int ROB_DEPTH = 16,
  parameter int ISSUE_W   = 2,
  localparam int AREG_W   = $clog2(NUM_ARCH),
  localparam int TAG_W    = $clog2(ROB_DEPTH),
  localparam int NSRC     = ISSUE_W * 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      iss_valid,
  input logic                      iss_ready,
  input logic [ISSUE_W-1:0]        iss_dst_we,
  input logic [ISSUE_W*AREG_W-1:0] iss_dst,
  input logic [ISSUE_W*TAG_W-1:0]  iss_tag,
  input logic [NSRC*AREG_W-1:0]    iss_src,
  input logic [ROB_DEPTH-1:0]      rob_done,
  input logic                      cmt_valid,
  input logic [AREG_W-1:0]         cmt_reg,
  input logic [TAG_W-1:0]          cmt_tag,
  input logic                      flush,
  input logic [NSRC*2-1:0]         src_sel,
  input logic [NSRC*TAG_W-1:0]     src_tag
);
  logic acc;
  assign acc = iss_valid && iss_ready;

  p_zero_rf_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_src[AREG_W-1:0] == '0) |-> (src_sel[1:0] == 2'd0));

  p_legal_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel[1:0] != 2'd3);

  p_flush_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (src_sel[1:0] == 2'd0));

  if (ISSUE_W >= 2) begin : g_pair
    p_rename_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && iss_dst_we[0] && (iss_dst[AREG_W-1:0] != '0) &&
       !(iss_dst_we[1] && (iss_dst[AREG_W +: AREG_W] == iss_dst[AREG_W-1:0])))
      |=> ((iss_src[AREG_W-1:0] != $past(iss_dst[AREG_W-1:0])) ||
           ((src_sel[1:0] != 2'd0) && (src_tag[TAG_W-1:0] == $past(iss_tag[TAG_W-1:0])))));

    p_group_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && iss_dst_we[0] && (iss_dst[AREG_W-1:0] != '0) &&
       (iss_src[2*AREG_W +: AREG_W] == iss_dst[AREG_W-1:0]))
      |-> ((src_sel[5:4] == 2'd2) && (src_tag[2*TAG_W +: TAG_W] == iss_tag[TAG_W-1:0])));
  end
endmodule

bind rename_status_table rst_checker #(
  .NUM_ARCH (NUM_ARCH),
  .ROB_DEPTH(ROB_DEPTH),
  .ISSUE_W  (ISSUE_W)
) u_rst_checker (.*);

// File: tb/test_rename_status_table.sv
`timescale 1ns/100ps
module test_rename_status_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid;
  logic        iss_ready;
  logic [1:0]  iss_dst_we;
  logic [9:0]  iss_dst;
  logic [7:0]  iss_tag;
  logic [19:0] iss_src;
  logic [15:0] rob_done;
  logic        cmt_valid;
  logic [4:0]  cmt_reg;
  logic [3:0]  cmt_tag;
  logic        flush;
  logic [7:0]  src_sel;
  logic [15:0] src_tag;

  int checks = 0;
  int errors = 0;
  bit       mbusy [32];
  bit [3:0] mtag  [32];

  always #2.5 clk = ~clk;

  rename_status_table i_rename_status_table (.*);

  task automatic idle();
    iss_valid = 0; iss_dst_we = 0; iss_dst = 0; iss_tag = 0; iss_src = 0;
    cmt_valid = 0; cmt_reg = 0; cmt_tag = 0; flush = 0;
  endtask

  // Model of the table from the requirements, applied on each edge.
  task automatic tick();
    bit fire;
    fire = iss_valid && !flush;
    if (flush) begin
      for (int r = 0; r < 32; r++) mbusy[r] = 0;
    end else begin
      if (cmt_valid && mbusy[cmt_reg] && mtag[cmt_reg] == cmt_tag) mbusy[cmt_reg] = 0;
      for (int s = 0; s < 2; s++)
        if (fire && iss_dst_we[s] && iss_dst[s*5 +: 5] != 0) begin
          mbusy[iss_dst[s*5 +: 5]] = 1;
          mtag[iss_dst[s*5 +: 5]]  = iss_tag[s*4 +: 4];
        end
    end
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic check(string req, int idx, logic [1:0] es, logic [3:0] et);
    checks++;
    if (src_sel[idx*2 +: 2] !== es || src_tag[idx*4 +: 4] !== et) begin
      errors++;
      $display("FAIL %s src%0d sel=%0d tag=%0d expected sel=%0d tag=%0d",
               req, idx, src_sel[idx*2 +: 2], src_tag[idx*4 +: 4], es, et);
    end
  endtask

  task automatic sweep(string req);
    for (int r = 0; r < 32; r++) begin
      logic [1:0] es;
      logic [3:0] et;
      iss_src[4:0] = 5'(r);
      iss_src[9:5] = 5'(31 - r);
      #1;
      if (r == 0 || !mbusy[r]) begin es = 0; et = 0; end
      else begin et = mtag[r]; es = rob_done[mtag[r]] ? 2'd1 : 2'd2; end
      check(req, 0, es, et);
      if (31 - r == 0 || !mbusy[31 - r]) begin es = 0; et = 0; end
      else begin et = mtag[31 - r]; es = rob_done[mtag[31 - r]] ? 2'd1 : 2'd2; end
      check(req, 1, es, et);
    end
    iss_src = 0;
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rob_done = 0;
    for (int r = 0; r < 32; r++) begin mbusy[r] = 0; mtag[r] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    sweep("R1 R3");

    // Rename every register, including register 0, one per cycle.
    for (int r = 0; r < 32; r++) begin
      iss_valid = 1; iss_dst_we = 2'b01; iss_dst[4:0] = 5'(r); iss_tag[3:0] = 4'(r);
      #1;
      checks++;
      if (iss_ready !== 1'b1) begin errors++; $display("FAIL R9 ready=%0b expected 1", iss_ready); end
      tick();
    end
    sweep("R2 R5 R12");

    rob_done = 16'hFFFF;
    sweep("R4 R6");
    rob_done = 16'h00FF;
    sweep("R4 R5 R6");

    // Commits with stale tags on odd registers.
    for (int r = 1; r < 32; r += 2) begin
      cmt_valid = 1; cmt_reg = 5'(r); cmt_tag = mtag[r] + 4'd1;
      tick();
    end
    sweep("R8");
    // Matching commits on even registers.
    for (int r = 2; r < 32; r += 2) begin
      cmt_valid = 1; cmt_reg = 5'(r); cmt_tag = mtag[r];
      tick();
    end
    sweep("R7 R3");

    // Intra-group lookup: slot 0 renames r5, slot 1 reads it.
    rob_done = 16'hFFFF;
    iss_valid = 1; iss_dst_we = 2'b01; iss_dst[4:0] = 5'd5; iss_tag[3:0] = 4'd11;
    iss_src[4:0] = 5'd5; iss_src[14:10] = 5'd5; iss_src[19:15] = 5'd0;
    #1;
    check("R10 younger", 2, 2'd2, 4'd11);
    check("R10 own", 0, 2'd1, 4'd5);
    check("R12 group", 3, 2'd0, 4'd0);
    // Slot 0 names register 0 as destination: slot 1 still reads the file.
    iss_dst[4:0] = 5'd0; iss_src[14:10] = 5'd0;
    #1;
    check("R12 dst0", 2, 2'd0, 4'd0);
    iss_dst[4:0] = 5'd5; iss_src[14:10] = 5'd5;
    #1;
    tick();
    sweep("R10 R2");

    // Two writers of r7 in one group.
    rob_done = 16'h0000;
    iss_valid = 1; iss_dst_we = 2'b11; iss_dst = {5'd7, 5'd7}; iss_tag = {4'd2, 4'd1};
    tick();
    iss_src[4:0] = 5'd7;
    #1;
    check("R11", 0, 2'd2, 4'd2);
    sweep("R11");

    // Rename and matching commit of r9 on the same edge.
    iss_valid = 1; iss_dst_we = 2'b01; iss_dst[4:0] = 5'd9; iss_tag[3:0] = 4'd12;
    cmt_valid = 1; cmt_reg = 5'd9; cmt_tag = mtag[9];
    tick();
    iss_src[4:0] = 5'd9;
    #1;
    check("R13", 0, 2'd2, 4'd12);
    sweep("R13");

    // Flush with a group presented.
    iss_valid = 1; iss_dst_we = 2'b11; iss_dst = {5'd4, 5'd3}; iss_tag = {4'd6, 4'd4};
    flush = 1;
    #1;
    checks++;
    if (iss_ready !== 1'b0) begin errors++; $display("FAIL R9 ready=%0b expected 0", iss_ready); end
    tick();
    sweep("R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule